// File: doc/BRIEF.md
# Byte-Stepped I2C Master Engine

This block is an I2C master that performs exactly one bus action each time software asks for one. Software writes a control byte holding start, stop and acknowledge requests together with the interrupt enable and the SI flag. Writing SI as zero while the engine is idle starts the action that those bits select. The action is one of four: a START, a repeated START, a STOP, or a nine-bit byte slot. In a byte slot the engine either sends the data register and samples the acknowledge, or receives a byte and returns an acknowledge.

When the action ends, the engine loads a fixed status code and sets SI. Software branches on the status code to choose the next step. While SI is set, SCL stays low, so the bus is stretched until software answers. A STOP is the one action that does not set SI: it leaves the engine idle with status F8h.

SCL and SDA are open drain. An output enable of 1 pulls the line low. Every bit is built from four quarter periods, and each quarter lasts (divider + 1) clock cycles.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register (address 2) reads F8h, SI is 0, irq_o is 0, both line enables are 0, and the divider register (address 3) holds DIV_RESET.
- R2: The control register is at address 0, with bit 7 as interrupt enable, bit 5 as START request, bit 4 as STOP request, bit 3 as SI and bit 2 as acknowledge enable. The data register is at address 1. A control write with bit 3 equal to 0 and the engine idle launches an action. Writing bit 3 as 1 never sets SI and launches nothing.
- R3: A START request while the bus is free ends with status 08h. A START request while the bus is owned ends with status 10h. Both set SI.
- R4: The action after status 08h or 10h shifts out the data register MSB first as the address byte. If bit 0 is 0, it ends with 18h on ACK or 20h on NACK. If bit 0 is 1, it ends with 40h on ACK or 48h on NACK.
- R5: In transmit mode, an action after 18h, 20h, 28h or 30h sends the data register and ends with 28h on ACK or 30h on NACK.
- R6: In receive mode (after 40h, 48h, 50h or 58h) an action receives a byte into the data register. It drives ACK and ends with 50h when the acknowledge-enable bit was 1, and releases SDA and ends with 58h when that bit was 0.
- R7: A STOP request while the bus is owned produces a STOP condition. The engine then returns to status F8h with SI at 0 and both lines released. A STOP request while the bus is free is ignored.
- R8: irq_o is 1 exactly when the interrupt enable is set and SI is set.
- R9: While SI is set, SCL is held low.
- R10: One quarter bit lasts div+1 cycles, so SCL stays high for 2*(div+1) cycles in a byte slot. SI rises 3*(div+1) cycles after the write that launches a START, and 36*(div+1) cycles after the write that launches a byte slot.
- R11: During a byte slot, the engine changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The launching write is taken at clock edge E. SI then rises at edge E+3(div+1) for a START and at edge E+36(div+1) for a byte slot. The bench counts falling clock edges from the write until SI is seen and compares that count with the formula for the divider in use. For the SCL high time, the bench counts the falling edges at which SCL is high and expects 2(div+1). Status, data and line checks are sampled only after SI is up, or after a fixed wait that is longer than a STOP takes. A bus model in the bench acknowledges its own address and supplies read data.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {ACT_START, ACT_RSTART, ACT_STOP, ACT_XFER} act_e;

  localparam int CTL_INTEN = 7;
  localparam int CTL_STA   = 5;
  localparam int CTL_STO   = 4;
  localparam int CTL_SI    = 3;
  localparam int CTL_AA    = 2;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam int QTR_PER_BIT = 4;
  localparam int XFER_STEPS  = 9 * QTR_PER_BIT;
endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !run_i)     cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || div_i == '0)); // R10
endmodule

// File: rtl/i2cm_bitseq.sv
module i2cm_bitseq import i2cm_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  act_e       act_i,
  input  logic [7:0] tx_i,
  input  logic       rx_mode_i,
  input  logic       ack_out_i,
  input  logic       hold_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       nack_o,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  localparam int STEP_W = $clog2(XFER_STEPS);

  logic              busy_q, rxm_q, acko_q, nack_q;
  act_e              act_q;
  logic [STEP_W-1:0] step_q, last;
  logic [7:0]        tx_q, rx_q;
  logic [3:0]        bit_idx;
  logic [1:0]        qtr;

  assign bit_idx = 4'(step_q / QTR_PER_BIT);
  assign qtr     = 2'(step_q % QTR_PER_BIT);

  always_comb begin
    case (act_q)
      ACT_START:  last = STEP_W'(2);
      ACT_RSTART: last = STEP_W'(3);
      ACT_STOP:   last = STEP_W'(2);
      default:    last = STEP_W'(XFER_STEPS - 1);
    endcase
  end

  assign done_o = busy_q && tick_i && (step_q == last);
  assign busy_o = busy_q;
  assign rx_o   = rx_q;
  assign nack_o = nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= ACT_START;
      step_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxm_q  <= 1'b0;
      acko_q <= 1'b0;
      nack_q <= 1'b1;
    end else if (go_i && !busy_q) begin
      busy_q <= 1'b1;
      act_q  <= act_i;
      step_q <= '0;
      tx_q   <= tx_i;
      rxm_q  <= rx_mode_i;
      acko_q <= ack_out_i;
    end else if (busy_q && tick_i) begin
      // sample in the middle of the SCL-high half
      if (act_q == ACT_XFER && qtr == 2'd2) begin
        if (bit_idx < 4'd8) rx_q   <= {rx_q[6:0], sda_i};
        else                nack_q <= sda_i;
      end
      if (step_q == last) busy_q <= 1'b0;
      else                step_q <= step_q + 1'b1;
    end
  end

  always_comb begin
    scl_low_o = hold_i;
    sda_low_o = 1'b0;
    if (busy_q) begin
      case (act_q)
        ACT_START: begin
          scl_low_o = (step_q == 2);
          sda_low_o = (step_q != 0);
        end
        ACT_RSTART: begin
          scl_low_o = (step_q == 0) || (step_q == 3);
          sda_low_o = (step_q >= 2);
        end
        ACT_STOP: begin
          scl_low_o = (step_q == 0);
          sda_low_o = (step_q != 2);
        end
        default: begin
          scl_low_o = (qtr < 2'd2);
          if (bit_idx < 4'd8) sda_low_o = !rxm_q && !tx_q[3'd7 - bit_idx[2:0]];
          else                sda_low_o = rxm_q && acko_q;
        end
      endcase
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> step_q <= last); // R10
  AST_SDA_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && act_q == ACT_XFER && qtr == 2'd3) |-> $stable(sda_low_o)); // R11
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2cm_pkg::*; #(
  parameter int          DIV_W     = 8,
  parameter int unsigned DIV_RESET = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic             inten_q, sta_q, sto_q, aa_q, si_q;
  logic             own_q, rxmode_q, addrph_q, rdbit_q, cur_aa_q;
  logic [7:0]       data_q, stat_q;
  logic [DIV_W-1:0] div_q;
  act_e             cur_act_q, act;
  logic             ctl_wr, go, addr_now, tick, busy, seq_done, nack;
  logic             scl_low, sda_low;
  logic [7:0]       rx_byte;

  assign ctl_wr   = wr_i && (addr_i == A_CTL);
  assign addr_now = (stat_q == ST_START) || (stat_q == ST_RSTART);

  always_comb begin
    go  = 1'b0;
    act = ACT_XFER;
    if (ctl_wr && !wdata_i[CTL_SI] && !busy) begin
      if (wdata_i[CTL_STO] && own_q) begin
        go = 1'b1; act = ACT_STOP;
      end else if (wdata_i[CTL_STA]) begin
        go = 1'b1; act = own_q ? ACT_RSTART : ACT_START;
      end else if (own_q) begin
        go = 1'b1; act = ACT_XFER;
      end
    end
  end

  i2cm_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(go), .run_i(busy),
    .div_i (div_q), .tick_o(tick)
  );

  i2cm_bitseq i_bitseq (
    .clk_i    (clk_i),   .rst_ni   (rst_ni),  .go_i     (go),
    .act_i    (act),     .tx_i     (data_q),
    .rx_mode_i(!addr_now && rxmode_q),
    .ack_out_i(wdata_i[CTL_AA]),
    .hold_i   (own_q),   .tick_i   (tick),    .sda_i    (sda_i),
    .busy_o   (busy),    .done_o   (seq_done),.rx_o     (rx_byte),
    .nack_o   (nack),    .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inten_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0; aa_q <= 1'b0; si_q <= 1'b0;
      own_q <= 1'b0; rxmode_q <= 1'b0; addrph_q <= 1'b0; rdbit_q <= 1'b0; cur_aa_q <= 1'b0;
      data_q <= '0; stat_q <= ST_IDLE; div_q <= DIV_W'(DIV_RESET); cur_act_q <= ACT_START;
    end else begin
      if (ctl_wr) begin
        inten_q <= wdata_i[CTL_INTEN];
        sta_q   <= wdata_i[CTL_STA];
        sto_q   <= wdata_i[CTL_STO];
        aa_q    <= wdata_i[CTL_AA];
        if (!wdata_i[CTL_SI]) si_q <= 1'b0;
      end
      if (wr_i && addr_i == A_DATA) data_q <= wdata_i;
      if (wr_i && addr_i == A_DIV)  div_q  <= DIV_W'(wdata_i);
      if (go) begin
        cur_act_q <= act;
        addrph_q  <= addr_now;
        rdbit_q   <= data_q[0];
        cur_aa_q  <= wdata_i[CTL_AA];
      end
      if (seq_done) begin
        case (cur_act_q)
          ACT_START:  begin stat_q <= ST_START;  si_q <= 1'b1; own_q <= 1'b1; rxmode_q <= 1'b0; end
          ACT_RSTART: begin stat_q <= ST_RSTART; si_q <= 1'b1; rxmode_q <= 1'b0; end
          ACT_STOP:   begin stat_q <= ST_IDLE;   own_q <= 1'b0; rxmode_q <= 1'b0; end
          default: begin
            si_q <= 1'b1;
            if (addrph_q) begin
              rxmode_q <= rdbit_q;
              if (rdbit_q) stat_q <= nack ? ST_AR_NACK : ST_AR_ACK;
              else         stat_q <= nack ? ST_AW_NACK : ST_AW_ACK;
            end else if (rxmode_q) begin
              data_q <= rx_byte;
              stat_q <= cur_aa_q ? ST_RX_ACK : ST_RX_NACK;
            end else begin
              stat_q <= nack ? ST_TX_NACK : ST_TX_ACK;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CTL:   rdata_o = {inten_q, 1'b0, sta_q, sto_q, si_q, aa_q, 2'b00};
      A_DATA:  rdata_o = data_q;
      A_STAT:  rdata_o = stat_q;
      default: rdata_o = 8'(div_q);
    endcase
  end

  assign irq_o    = inten_q && si_q;
  assign scl_oe_o = scl_low;
  assign sda_oe_o = sda_low;

  AST_SCL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    si_q |-> scl_oe_o); // R9
  AST_SI_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done && cur_act_q != ACT_STOP) |=> si_q); // R3
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done && cur_act_q == ACT_STOP) |=> (stat_q == ST_IDLE && !si_q && !scl_oe_o && !sda_oe_o)); // R7
  AST_FREE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_q && !busy) |-> (!scl_oe_o && !sda_oe_o)); // R7
  AST_NO_RELAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wdata_i[CTL_SI]) |-> !go); // R2
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic s_pull = 0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_pull);
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_byte_master i_i2c_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // bus model: target address 7'h50, NACKs data byte FF, read data counts up from A5
  localparam logic [6:0] SLV = 7'h50;
  int s_cnt = 0;
  bit s_act = 0, s_first = 0, s_rd = 0, s_sel = 0, s_mack = 0;
  logic [7:0] s_sh = 0, s_rb = 8'hA5;

  always @(negedge sda_w) if (scl_w) begin s_act = 1; s_cnt = -1; s_first = 1; s_pull = 0; end
  always @(posedge sda_w) if (scl_w) begin s_act = 0; s_pull = 0; end
  always @(posedge scl_w) if (s_act) begin
    if (s_cnt < 8) s_sh = {s_sh[6:0], sda_w};
    else s_mack = !sda_w;
  end
  always @(negedge scl_w) if (s_act) begin
    s_cnt++;
    if (s_cnt == 8) begin
      if (s_first) begin s_rd = s_sh[0]; s_sel = (s_sh[7:1] == SLV); s_pull = s_sel; end
      else if (!s_rd) s_pull = s_sel && (s_sh != 8'hFF);
      else begin s_pull = 0; s_rb++; end
    end else if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_first) begin s_first = 0; s_pull = s_sel && s_rd && !s_rb[7]; end
      else s_pull = s_rd && s_sel && s_mack && !s_rb[7];
    end else if (s_cnt >= 1 && s_rd && !s_first && s_sel) s_pull = !s_rb[7 - s_cnt];
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_si(output int n);
    logic [7:0] c;
    n = 0;
    c = 0;
    while (!c[3] && n < 20000) begin
      @(negedge clk); n++; addr = 2'd0; #1 c = rdata;
    end
  endtask

  task automatic step(input logic [7:0] d, input logic [7:0] ctl, input logic [7:0] exp_st, input string tag);
    int n;
    logic [7:0] st;
    if (d !== 8'hxx) wr_reg(2'd1, d);
    wr_reg(2'd0, ctl);
    wait_si(n);
    rd_reg(2'd2, st);
    chk(tag, st, exp_st);
  endtask

  task automatic do_stop(input string tag);
    logic [7:0] st, c;
    wr_reg(2'd0, 8'h10);
    repeat (60) @(negedge clk);
    rd_reg(2'd2, st); chk({tag, " status F8"}, st, 8'hF8);
    rd_reg(2'd0, c);  chk({tag, " SI clear"}, c[3], 0);
    chk({tag, " lines free"}, {scl_w, sda_w}, 2'b11);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(2'd2, v); chk("R1 status", v, 8'hF8);
    rd_reg(2'd3, v); chk("R1 divider", v, 4);
    rd_reg(2'd0, v); chk("R1 SI", v[3], 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_idle_stop;
    logic [7:0] v;
    int hits = 0;
    wr_reg(2'd0, 8'h10);
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (scl_oe || sda_oe) hits++; end
    chk("R7 idle STOP no line activity", hits, 0);
    rd_reg(2'd2, v); chk("R7 idle STOP status", v, 8'hF8);
    wr_reg(2'd0, 8'h08);
    repeat (60) @(negedge clk);
    rd_reg(2'd0, v); chk("R2 SI write-1 ignored", v[3], 0);
    rd_reg(2'd2, v); chk("R2 SI write-1 no action", v, 8'hF8);
  endtask

  task automatic t_write;
    int n, low = 0;
    logic [7:0] v;
    wr_reg(2'd0, 8'hA0);
    wait_si(n);
    chk("R10 START latency", n, 15);
    rd_reg(2'd2, v); chk("R3 START status", v, 8'h08);
    chk("R8 irq with enable", irq, 1);
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (!scl_oe) low++; end
    chk("R9 SCL held while SI", low, 0);
    wr_reg(2'd0, 8'h88);
    repeat (60) @(negedge clk);
    rd_reg(2'd2, v); chk("R2 SI=1 write launches nothing", v, 8'h08);
    wr_reg(2'd1, 8'hA0);
    wr_reg(2'd0, 8'h80);
    wait_si(n);
    chk("R10 byte latency", n, 180);
    rd_reg(2'd2, v); chk("R4 SLA+W ACK", v, 8'h18);
    step(8'h3C, 8'h80, 8'h28, "R5 data ACK");
    step(8'hFF, 8'h80, 8'h30, "R5 data NACK");
    step(8'h5A, 8'h80, 8'h28, "R5 data after NACK");
    do_stop("R7 write");
    chk("R8 irq low after STOP", irq, 0);
  endtask

  task automatic t_bad_addr;
    logic [7:0] v;
    step(8'hxx, 8'h20, 8'h08, "R3 START no irq enable");
    chk("R8 irq masked", irq, 0);
    step(8'hC4, 8'h00, 8'h20, "R4 SLA+W NACK");
    do_stop("R7 bad addr");
    rd_reg(2'd0, v);
  endtask

  task automatic t_read;
    logic [7:0] v;
    step(8'hxx, 8'h20, 8'h08, "R3 START");
    step(8'hA0, 8'h00, 8'h18, "R4 SLA+W");
    step(8'hxx, 8'h20, 8'h10, "R3 repeated START");
    step(8'hA1, 8'h04, 8'h40, "R4 SLA+R ACK");
    step(8'hxx, 8'h04, 8'h50, "R6 read ACK");
    rd_reg(2'd1, v); chk("R6 read byte 1", v, 8'hA5);
    chk("R9 SCL held after read", scl_oe, 1);
    step(8'hxx, 8'h00, 8'h58, "R6 read NACK");
    rd_reg(2'd1, v); chk("R6 read byte 2", v, 8'hA6);
    do_stop("R7 read");
    step(8'hxx, 8'h20, 8'h08, "R3 START 2");
    step(8'hC5, 8'h00, 8'h48, "R4 SLA+R NACK");
    do_stop("R7 read nack");
  endtask

  task automatic t_divider;
    int n, hi = 0;
    wr_reg(2'd3, 8'd9);
    wr_reg(2'd0, 8'h20);
    wait_si(n);
    chk("R10 START latency div 9", n, 30);
    wr_reg(2'd1, 8'hA0);
    wr_reg(2'd0, 8'h00);
    while (!scl_w) @(negedge clk);
    while (scl_w) begin hi++; @(negedge clk); end
    chk("R10 SCL high time div 9", hi, 20);
    wait_si(n);
    do_stop("R7 divider");
    wr_reg(2'd3, 8'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle_stop();
    t_write();
    t_bad_addr();
    t_read();
    t_divider();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule